// File: doc/BRIEF.md
# Strap-latched frequency select controller

This block handles the five dual-purpose select pins of a clock generator. While power-on reset is in progress, the pins are inputs that carry resistor straps. The block captures their levels once, on the power-on-reset-done pulse, and holds them until the next reset. After the capture it turns the pins around into clock outputs.

From then on, a mode bit in an 8-bit configuration byte chooses where the active 5-bit frequency code comes from. The code is either the held strap value or a field of the configuration byte. The block then derives three things from the chosen code and the byte:
- the CPU-to-PCI divide ratio (2, 3 or 4, by code range);
- a spread-spectrum enable;
- a global output tristate.

The held strap bits are also presented in inverted form for read-back through the register path.

Top module: `fsel_strap_ctrl`

## Requirements
- R1: While `rst` is high, at each clock edge the outputs go to these values: `fcode_o` = 0, `pci_div_o` = 0 (divide by 2), `pad_oe_o` = 0, `spread_en_o` = 0, `tristate_o` = 0, and `strap_rb_o` = 5'h1F. The latch is cleared to 0, and its inversion gives 5'h1F.
- R2: At the first edge after reset where `por_done_i` is high, the latch stores `strap_i`. From that same edge, `strap_rb_o` shows the bitwise inverse of the stored value. With `cfg_byte_i[3]` = 0, the stored value appears on `fcode_o` one edge later.
- R3: The latch captures only once per reset. Later `por_done_i` pulses have no effect on `fcode_o` or `strap_rb_o`, and neither do later changes of `strap_i`.
- R4: `pad_oe_o` (1 = pins drive as outputs) stays 0 up to and including the capture edge. It rises at the edge after the capture and then stays 1 until reset.
- R5: `cfg_byte_i[3]` selects the code source. A 0 selects the held straps. A 1 selects the register code {`cfg_byte_i[2]`, `cfg_byte_i[7:4]`}, with bit 2 as the MSB. `fcode_o` follows the selection one edge after the inputs are applied.
- R6: `pci_div_o` is registered together with `fcode_o` and gives the ratio for that code. Codes 0–15 give 0 (divide by 2). Codes 16–29 give 1 (divide by 3). Codes 30–31 give 2 (divide by 4).
- R7: `spread_en_o` equals `cfg_byte_i[1]` as sampled at the previous edge.
- R8: `tristate_o` equals `cfg_byte_i[0]` as sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on reset in progress) |
| por_done_i | input | 1 | Pulse marking the end of power-on reset; triggers the strap capture |
| strap_i | input | 5 | Strap levels read from the select pins |
| cfg_byte_i | input | 8 | Configuration byte: [0] tristate, [1] spread, [2] code MSB, [3] source select, [7:4] code low bits |
| fcode_o | output | 5 | Active frequency code |
| pci_div_o | output | 2 | PCI divide select: 0 = /2, 1 = /3, 2 = /4 |
| pad_oe_o | output | 1 | Select-pin direction: 1 = output drive enabled |
| strap_rb_o | output | 5 | Inverted held strap value for read-back |
| spread_en_o | output | 1 | Spread-spectrum enable |
| tristate_o | output | 1 | Global output tristate |

## Verification
The code source is switched in both directions. Hardware mode is run with two different captured strap values across separate resets, and register mode is tried with codes whose bits differ from the straps. A wrong selection, a field taken from the wrong bits, or a swapped MSB therefore each show up as a different code.

Register codes 0, 15, 16, 29, 30 and 31 sit on both sides of each divide boundary, so an off-by-one range threshold is told apart from a correct one.

Repeat capture pulses with new strap levels, and strap changes without any pulse, show whether the latch is really one-shot. Observing `pad_oe_o` on the capture edge and on the edge after it separates a correct one-cycle turnaround from an early one.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    localparam int FS_W      = 5;
    localparam int CFG_W     = 8;
    localparam int DIV_W     = 2;
    localparam int NUM_CODES = 1 << FS_W;

    // Byte bit positions, decoded by the register path
    localparam int CFG_TRI_BIT = 0;
    localparam int CFG_SPR_BIT = 1;
    localparam int CFG_MSB_BIT = 2;
    localparam int CFG_SRC_BIT = 3;
    localparam int CFG_LO_TOP  = 7;
    localparam int CFG_LO_BOT  = 4;

    typedef enum logic [DIV_W-1:0] {
        DIV_BY2 = 2'd0,
        DIV_BY3 = 2'd1,
        DIV_BY4 = 2'd2
    } pci_div_e;

    typedef enum logic {
        SRC_STRAP = 1'b0,
        SRC_REG   = 1'b1
    } code_src_e;

    typedef struct packed {
        logic [FS_W-1:0] code;
        pci_div_e        div;
        logic            spread;
        logic            tristate;
    } fsel_out_t;

    function automatic logic [FS_W-1:0] reg_code(input logic [CFG_W-1:0] cfg);
        return {cfg[CFG_MSB_BIT], cfg[CFG_LO_TOP:CFG_LO_BOT]};
    endfunction

    function automatic pci_div_e code_to_div(input logic [FS_W-1:0] code,
                                             input int div3_first,
                                             input int div4_first);
        pci_div_e r;
        if (int'(code) >= div4_first)      r = DIV_BY4;
        else if (int'(code) >= div3_first) r = DIV_BY3;
        else                               r = DIV_BY2;
        return r;
    endfunction

endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch
    import fsel_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            por_done_i,
    input  logic [FS_W-1:0] strap_i,
    output logic [FS_W-1:0] latch_o,
    output logic            captured_o
);

    logic [FS_W-1:0] latch_q;
    logic            cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            cap_q   <= 1'b0;
        end else if (por_done_i && !cap_q) begin
            latch_q <= strap_i;
            cap_q   <= 1'b1;
        end
    end

    assign latch_o    = latch_q;
    assign captured_o = cap_q;

    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (rst)
        (por_done_i && !cap_q) |=> (latch_q == $past(strap_i)) && cap_q); // R2

    AST_CAPTURE_ONCE: assert property (@(posedge clk) disable iff (rst)
        cap_q |=> $stable(latch_q) && cap_q); // R3

endmodule

// File: rtl/fsel_code_select.sv
module fsel_code_select
    import fsel_pkg::*;
(
    input  logic [FS_W-1:0]  strap_code_i,
    input  logic [CFG_W-1:0] cfg_i,
    output logic [FS_W-1:0]  code_o
);

    code_src_e src;

    always_comb begin
        src    = code_src_e'(cfg_i[CFG_SRC_BIT]);
        code_o = (src == SRC_REG) ? reg_code(cfg_i) : strap_code_i;
    end

endmodule

// File: rtl/fsel_div_decode.sv
module fsel_div_decode
    import fsel_pkg::*;
#(
    parameter int DIV3_FIRST = 16,
    parameter int DIV4_FIRST = 30
) (
    input  logic [FS_W-1:0] code_i,
    output pci_div_e        div_o
);

    always_comb begin
        div_o = code_to_div(code_i, DIV3_FIRST, DIV4_FIRST);
    end

    initial begin
        assert (DIV3_FIRST < DIV4_FIRST && DIV4_FIRST <= NUM_CODES)
            else $error("divide thresholds out of order");
    end

endmodule

// File: rtl/fsel_strap_ctrl.sv
module fsel_strap_ctrl
    import fsel_pkg::*;
#(
    parameter int DIV3_FIRST = 16,
    parameter int DIV4_FIRST = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             por_done_i,
    input  logic [FS_W-1:0]  strap_i,
    input  logic [CFG_W-1:0] cfg_byte_i,
    output logic [FS_W-1:0]  fcode_o,
    output logic [DIV_W-1:0] pci_div_o,
    output logic             pad_oe_o,
    output logic [FS_W-1:0]  strap_rb_o,
    output logic             spread_en_o,
    output logic             tristate_o
);

    logic [FS_W-1:0] latch_w;
    logic            captured_w;
    logic [FS_W-1:0] sel_code_w;
    pci_div_e        div_w;
    fsel_out_t       out_d;
    fsel_out_t       out_q;
    logic            oe_q;

    fsel_strap_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .por_done_i (por_done_i),
        .strap_i    (strap_i),
        .latch_o    (latch_w),
        .captured_o (captured_w)
    );

    fsel_code_select u_sel (
        .strap_code_i (latch_w),
        .cfg_i        (cfg_byte_i),
        .code_o       (sel_code_w)
    );

    fsel_div_decode #(
        .DIV3_FIRST (DIV3_FIRST),
        .DIV4_FIRST (DIV4_FIRST)
    ) u_div (
        .code_i (sel_code_w),
        .div_o  (div_w)
    );

    always_comb begin
        out_d.code     = sel_code_w;
        out_d.div      = div_w;
        out_d.spread   = cfg_byte_i[CFG_SPR_BIT];
        out_d.tristate = cfg_byte_i[CFG_TRI_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '{code: '0, div: DIV_BY2, spread: 1'b0, tristate: 1'b0};
            oe_q  <= 1'b0;
        end else begin
            out_q <= out_d;
            oe_q  <= captured_w;
        end
    end

    assign fcode_o     = out_q.code;
    assign pci_div_o   = out_q.div;
    assign spread_en_o = out_q.spread;
    assign tristate_o  = out_q.tristate;
    assign pad_oe_o    = oe_q;
    assign strap_rb_o  = ~latch_w;

    AST_OE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        $rose(pad_oe_o) |-> $past(captured_w)); // R4

    AST_OE_STAYS: assert property (@(posedge clk) disable iff (rst)
        pad_oe_o |=> pad_oe_o); // R4

    AST_REG_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (cfg_byte_i[CFG_SRC_BIT]) |=>
            fcode_o == $past({cfg_byte_i[CFG_MSB_BIT], cfg_byte_i[CFG_LO_TOP:CFG_LO_BOT]})); // R5

    AST_DIV_BY4_RANGE: assert property (@(posedge clk) disable iff (rst)
        (int'(fcode_o) >= DIV4_FIRST) |-> pci_div_o == DIV_BY4); // R6

    AST_DIV_BY2_RANGE: assert property (@(posedge clk) disable iff (rst)
        (int'(fcode_o) < DIV3_FIRST) |-> pci_div_o == DIV_BY2); // R6

    AST_SPREAD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> spread_en_o == $past(cfg_byte_i[CFG_SPR_BIT])); // R7

    AST_TRI_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> tristate_o == $past(cfg_byte_i[CFG_TRI_BIT])); // R8

endmodule

// File: tb/fsel_strap_ctrl_bench.sv
module fsel_strap_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       por_done = 1'b0;
    logic [4:0] strap = 5'h00;
    logic [7:0] cfg = 8'h00;
    logic [4:0] fcode;
    logic [1:0] pci_div;
    logic       pad_oe;
    logic [4:0] strap_rb;
    logic       spread_en;
    logic       tristate;

    always #2 clk = ~clk;

    fsel_strap_ctrl u_fsel_strap_ctrl (
        .clk         (clk),
        .rst         (rst),
        .por_done_i  (por_done),
        .strap_i     (strap),
        .cfg_byte_i  (cfg),
        .fcode_o     (fcode),
        .pci_div_o   (pci_div),
        .pad_oe_o    (pad_oe),
        .strap_rb_o  (strap_rb),
        .spread_en_o (spread_en),
        .tristate_o  (tristate)
    );

    typedef struct {
        int         due;
        logic [4:0] code;
        logic [1:0] div;
        logic       oe;
        logic [4:0] rb;
        logic       spr;
        logic       tri_s;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    logic m_cap = 1'b0;
    logic [4:0] m_lat = 5'h00;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [1:0] exp_div(input logic [4:0] c);
        if (c == 5'd30 || c == 5'd31) return 2'd2;
        if (c >= 5'd16) return 2'd1;
        return 2'd0;
    endfunction

    task automatic step(input logic r, input logic por, input logic [4:0] s,
                        input logic [7:0] c, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; por_done = por; strap = s; cfg = c;
        e.due = cyc + 1;
        e.tag = tag;
        if (r) begin
            m_cap = 1'b0; m_lat = 5'h00;
            e.code = 5'h00; e.div = 2'd0; e.oe = 1'b0; e.spr = 1'b0; e.tri_s = 1'b0;
        end else begin
            e.code  = c[3] ? {c[2], c[7:4]} : m_lat;
            e.div   = exp_div(e.code);
            e.oe    = m_cap;
            e.spr   = c[1];
            e.tri_s = c[0];
            if (por && !m_cap) begin
                m_lat = s; m_cap = 1'b1;
            end
        end
        e.rb = ~m_lat;
        q.push_back(e);
    endtask

    function automatic logic [7:0] regcfg(input logic [4:0] code, input logic spr, input logic tri_b);
        return {code[3:0], 1'b1, code[4], spr, tri_b};
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (fcode !== e.code || pci_div !== e.div || pad_oe !== e.oe ||
                    strap_rb !== e.rb || spread_en !== e.spr || tristate !== e.tri_s) begin
                    errors++;
                    $display("FAIL %s cyc %0d actual code=%0d div=%0d oe=%0b rb=%h spr=%0b tri=%0b expected code=%0d div=%0d oe=%0b rb=%h spr=%0b tri=%0b",
                             e.tag, cyc, fcode, pci_div, pad_oe, strap_rb, spread_en, tristate,
                             e.code, e.div, e.oe, e.rb, e.spr, e.tri_s);
                end
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset values, strap ignored during reset
        step(1, 0, 5'h13, 8'h00, "R1");
        step(1, 1, 5'h13, 8'hFF, "R1");
        step(1, 0, 5'h13, 8'h00, "R1");
        // R4 no drive before capture
        step(0, 0, 5'h13, 8'h00, "R4");
        step(0, 0, 5'h13, 8'h00, "R4");
        // R2 capture edge, oe still low on it (R4)
        step(0, 1, 5'h13, 8'h00, "R2");
        step(0, 0, 5'h13, 8'h00, "R2_R4_R6");
        // R3 repeat pulses and strap changes ignored
        step(0, 1, 5'h05, 8'h00, "R3");
        step(0, 0, 5'h0A, 8'h00, "R3");
        step(0, 1, 5'h1F, 8'h00, "R3");
        step(0, 0, 5'h1F, 8'h00, "R3");
        // R5 R6 register source across divide boundaries
        step(0, 0, 5'h00, regcfg(5'd0,  0, 0), "R5_R6");
        step(0, 0, 5'h00, regcfg(5'd15, 0, 0), "R5_R6");
        step(0, 0, 5'h00, regcfg(5'd16, 0, 0), "R5_R6");
        step(0, 0, 5'h00, regcfg(5'd29, 0, 0), "R5_R6");
        step(0, 0, 5'h00, regcfg(5'd30, 0, 0), "R5_R6");
        step(0, 0, 5'h00, regcfg(5'd31, 0, 0), "R5_R6");
        step(0, 0, 5'h00, regcfg(5'd20, 0, 0), "R5");
        step(0, 0, 5'h00, regcfg(5'd11, 0, 0), "R5");
        // R7 R8 spread and tristate
        step(0, 0, 5'h00, regcfg(5'd11, 1, 0), "R7");
        step(0, 0, 5'h00, regcfg(5'd11, 0, 1), "R8");
        step(0, 0, 5'h00, 8'h03, "R7_R8");
        step(0, 0, 5'h00, 8'h02, "R7_R8");
        // R5 back to strap source, field bits set but ignored
        step(0, 0, 5'h00, 8'hF4, "R5");
        step(0, 0, 5'h00, 8'h00, "R5");
        // second reset, new strap value
        step(1, 0, 5'h1F, 8'h00, "R1");
        step(0, 1, 5'h1E, 8'h00, "R2");
        step(0, 0, 5'h00, 8'h00, "R2_R6");
        step(0, 1, 5'h01, 8'h00, "R3");
        step(0, 0, 5'h01, 8'h00, "R3");
        step(0, 0, 5'h01, 8'h00, "R4");
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard actual %0d pending expected 0", q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule